// File: doc/BRIEF.md
# Byte-Loaded Watchdog Reset Timer

This block is a one-shot watchdog. An upstream agent programs it by streaming a 32-bit control word as four strobed bytes, least-significant byte first. The fourth byte completes the word and the block answers with a one-cycle done pulse, which lets the upstream side release its connection. The same edge loads a cycle countdown from the low 29 bits of the word.

When the countdown runs out, the block raises a one-cycle reset request. Bit 29 of the word chooses the request line: the global line, which resets every module, or the local line, which resets only the owning module. A count of zero disables the timer. Writing an all-zero word at any time cancels a countdown that is running. After it fires once, the timer stays idle until it is loaded again. Stretching the request into a long reset belongs to a separate reset circuit.

Top module: `wdog_byte_timer`

## Requirements
- R1: Bytes qualified by `byte_vld` fill the word in arrival order. The first byte goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. Idle cycles may fall between bytes.
- R2: `load_done` is high for exactly one cycle, the cycle after the fourth byte is accepted. It stays low after the first three bytes.
- R3: For a loaded count N in bits 28:0, with 1 <= N <= 2^29-1, the reset request is high exactly N cycles after the cycle in which `load_done` is high.
- R4: When bit 29 is 1, expiry raises `glob_rst_req`. When bit 29 is 0, expiry raises `loc_rst_req`. The two lines are never high together.
- R5: A loaded count of zero issues no reset request at all.
- R6: Loading an all-zero word while a countdown runs cancels it, and no request follows.
- R7: Loading a new nonzero word while a countdown runs restarts the countdown from the new value.
- R8: Each expiry gives a single one-cycle pulse. After it, no further request occurs until the timer is loaded again.
- R9: Bits 31 and 30 of the word have no effect on the count or the scope.
- R10: While `rst_n` is low, all outputs are low and the timer is disarmed. The byte position returns to the first byte, so any partial load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | Qualifies `byte_data` in this cycle |
| byte_data | input | 8 | Control word byte |
| load_done | output | 1 | One-cycle pulse after the fourth byte |
| glob_rst_req | output | 1 | One-cycle global reset request |
| loc_rst_req | output | 1 | One-cycle local reset request |

## Verification
The bench loads counts of 1, 256 and several small values. A timer that is off by one cycle, or that fires immediately on a count of 1, shows up in the exact pulse cycle. The 256 count places a set bit in the second byte, so a design that assembles the bytes in the wrong order fires at the wrong time. Words with bits 31:30 set expose a design that decodes the scope from the wrong bit. Cancel, restart and post-expiry windows catch a timer that fires twice, keeps counting after a zero load, or keeps the old count on a reload. A reset issued in the middle of a load catches a byte index that is not cleared, which would misalign every later word.

// File: rtl/wdog_byte_timer.sv
module wdog_byte_timer #(
  parameter int CNT_W = 29
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output logic       load_done,
  output logic       glob_rst_req,
  output logic       loc_rst_req
);
  localparam int LOW_W = 24;
  localparam int TOP_CNT = CNT_W - LOW_W;

  logic [1:0]       idx;
  logic [LOW_W-1:0] shadow;
  logic [CNT_W-1:0] count;
  logic             armed, scope_glob;
  logic             done_q, glob_q, loc_q;

  wire last_byte = byte_vld && (idx == 2'd3);
  wire at_one    = (count == CNT_W'(1));
  wire expire    = armed && at_one && !last_byte;
  wire unused_hi = &{1'b0, byte_data[7:TOP_CNT+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      shadow     <= '0;
      count      <= '0;
      armed      <= 1'b0;
      scope_glob <= 1'b0;
      done_q     <= 1'b0;
      glob_q     <= 1'b0;
      loc_q      <= 1'b0;
    end else begin
      done_q <= last_byte;
      glob_q <= expire && scope_glob;
      loc_q  <= expire && !scope_glob;
      if (byte_vld) begin
        idx <= idx + 2'd1;
        if (idx != 2'd3) shadow[8*idx +: 8] <= byte_data;
      end
      if (last_byte) begin
        count      <= {byte_data[TOP_CNT-1:0], shadow};
        scope_glob <= byte_data[TOP_CNT];
        armed      <= |{byte_data[TOP_CNT-1:0], shadow};
      end else if (armed) begin
        if (at_one) armed <= 1'b0;
        else        count <= count - CNT_W'(1);
      end
    end
  end

  assign load_done    = done_q;
  assign glob_rst_req = glob_q;
  assign loc_rst_req  = loc_q;
endmodule

// File: rtl/wdog_byte_timer_chk.sv
module wdog_byte_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic load_done,
  input logic glob_rst_req,
  input logic loc_rst_req
);
  p_excl_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(glob_rst_req && loc_rst_req));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  p_done_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(byte_vld));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_rst_req || loc_rst_req) |=> !(glob_rst_req || loc_rst_req));

  p_reload_preempts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !(glob_rst_req || loc_rst_req));
endmodule

bind wdog_byte_timer wdog_byte_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .load_done(load_done),
  .glob_rst_req(glob_rst_req), .loc_rst_req(loc_rst_req)
);

// File: tb/wdog_byte_timer_bench.sv
`timescale 1ns/1ps
module wdog_byte_timer_bench;
  logic clk = 0, rst_n = 0, byte_vld = 0;
  logic [7:0] byte_data = 0;
  logic load_done, glob_rst_req, loc_rst_req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wdog_byte_timer u_wdog_byte_timer (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .load_done(load_done), .glob_rst_req(glob_rst_req), .loc_rst_req(loc_rst_req)
  );

  localparam int NV = 5;
  localparam logic [31:0] VEC_W [NV] = '{32'h2000_0001, 32'h0000_0005,
                                         32'hC000_0003, 32'hE000_0004, 32'h2000_0100};
  localparam int VEC_N [NV] = '{1, 5, 3, 4, 256};
  localparam bit VEC_G [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int gap);
    for (int b = 0; b < 4; b++) begin
      byte_vld = 1; byte_data = w[8*b +: 8];
      @(posedge clk); #1;
      byte_vld = 0; byte_data = 0;
      if (b < 3) begin
        check(load_done == 0, "R2 done early", load_done, 0);
        for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
      end
    end
    check(load_done == 1, "R2 done after byte 4", load_done, 1);
  endtask

  task automatic watch(input int n, input int exp_at, input bit exp_g, input string req);
    int cnt = 0, at = 0; bit g = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (k == 1 && load_done) check(0, "R2 done width", 1, 0);
      if (glob_rst_req && loc_rst_req) check(0, "R4 both lines", 1, 0);
      if (glob_rst_req || loc_rst_req) begin
        cnt++;
        if (cnt == 1) begin at = k; g = glob_rst_req; end
      end
    end
    if (exp_at == 0) check(cnt == 0, req, cnt, 0);
    else begin
      check(cnt == 1 && at == exp_at, req, at, exp_at);
      check(g == exp_g, "R4 scope", g, exp_g);
    end
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check(!load_done && !glob_rst_req && !loc_rst_req, "R10 reset outputs", 1, 0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      send_word(VEC_W[v], v % 3);
      watch(VEC_N[v] + 10, VEC_N[v], VEC_G[v], (v >= 2 && v <= 3) ? "R9 high bits" :
                                                 (v == 4) ? "R1 byte order" : "R3 count");
    end

    send_word(32'h2000_0000, 0);
    watch(30, 0, 0, "R5 zero disables");

    send_word(32'h2000_000A, 0);
    watch(3, 0, 0, "R6 pre-cancel");
    send_word(32'h0000_0000, 1);
    watch(30, 0, 0, "R6 cancel");

    send_word(32'h0000_000A, 0);
    watch(2, 0, 0, "R7 pre-restart");
    send_word(32'h2000_0006, 0);
    watch(20, 6, 1, "R7 restart");

    send_word(32'h0000_0003, 0);
    watch(40, 3, 0, "R8 single pulse");

    byte_vld = 1; byte_data = 8'hFF;
    @(posedge clk); #1;
    @(posedge clk); #1;
    byte_vld = 0; byte_data = 0; rst_n = 0;
    @(posedge clk); #1;
    check(!load_done && !glob_rst_req && !loc_rst_req, "R10 reset mid-load", 1, 0);
    rst_n = 1;
    send_word(32'h0000_0002, 0);
    watch(10, 2, 0, "R10 index cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule